// File: doc/BRIEF.md
# Prescaled Four-Channel Compare Timer

This block is a free-running 32-bit up counter with four compare channels. It is used to watch how long software tasks run. A programmable 8-bit divider sits between the system clock and the counter. Each channel holds its own 32-bit compare value and its own enable bit. A channel raises a sticky flag, and drives its interrupt line, when the counter steps onto that channel's compare value.

Software reaches every setting through a plain single-cycle register port. A write is taken on the rising clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The block carries no data stream, so there is no valid/ready handshake and no back-pressure: every write is accepted. A debug-halt input can freeze the counter when the freeze bit is set.

Register word addresses:
- 0: control register. Bit 0 is the run enable, bit 1 is the debug-freeze enable, and bits 15:8 hold the divider value N.
- 1: counter value.
- 2: flag register. Bit i belongs to channel i.
- 4+2i: channel i control. Bit 0 is the channel enable.
- 5+2i: channel i compare value.

Top module: `task_timer`

## Requirements
- R1: After reset, the control register, the counter, all compare values, all channel enables and all flags read 0, and `irq` is 0.
- R2: With divider value N (control bits 15:8) and run enable set (control bit 0), the counter increases by exactly 1 once every N+1 clocks. The divider restarts from phase 0 each time counting is enabled. The counter never changes by any other step, except through a write allowed by R3.
- R3: A write to the counter address (1) updates the counter only while run enable is 0. While run enable is 1 such a write is ignored.
- R4: The counter rolls over from 0xFFFFFFFF to 0. The rollover raises no flag for a channel whose compare value is not reached.
- R5: Channel i flag (flag register bit i, also `irq[i]`) becomes 1 on the same edge on which the counter steps onto channel i's compare value (address 5+2i), provided the channel is enabled.
- R6: A channel whose enable (bit 0 at address 4+2i) is 0 never sets its flag.
- R7: Writing 1 to bit i of the flag register (address 2) clears flag i. Writing 0 leaves the flag unchanged. A match on the same edge wins over the clear.
- R8: While debug-freeze enable (control bit 1) and `dbg_halt` are both 1, the counter and the divider hold their values. With freeze enable at 0, `dbg_halt` has no effect.
- R9: When run enable is 0, the divider phase is held at 0. After counting is re-enabled, the first step therefore comes N+1 clocks later.
- R10: Several channels with the same compare value all flag on the same edge, each on its own `irq` line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dbg_halt | input | 1 | Debug halt indication |
| irq | output | 4 | Per-channel interrupt, equal to the channel flags |

## Verification
Several rules are checked on every cycle:
- the counter only ever steps by one or is loaded while stopped;
- it holds while frozen, and cannot move by more than a step while running;
- the divider phase sits at zero whenever counting is off;
- a flag rises only on an enabled channel whose compare value the counter has just reached, and falls only under a clear.

The bench scenarios are needed for the exact step cadence at each divider value, and for the restart spacing after a re-enable. They also cover the rollover value, the ignored counter write while running, the priority of a match over a same-edge clear, and the simultaneous flagging of shared compare values.

// File: rtl/task_timer_pkg.sv
package task_timer_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_FRZ_BIT = 1;
  localparam int CTRL_PSC_LSB = 8;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_COUNT   = 1;
  localparam int ADDR_FLAGS   = 2;
  localparam int ADDR_CH_BASE = 4;
endpackage

// File: rtl/task_timer_prescaler.sv
module task_timer_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic [PW-1:0] div,
  output logic [PW-1:0] phase,
  output logic          tick
);
  assign tick = run && (phase == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= '0;
    else if (clr)   phase <= '0;
    else if (run)   phase <= (phase == div) ? '0 : phase + 1'b1;
  end
endmodule

// File: rtl/task_timer_counter.sv
module task_timer_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] nxt
);
  assign nxt = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= nxt;
  end
endmodule

// File: rtl/task_timer_channel.sv
module task_timer_channel #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          cmp_wr,
  input  logic [CW-1:0] wdata,
  input  logic          tick,
  input  logic [CW-1:0] nxt,
  input  logic          clr,
  output logic          en,
  output logic [CW-1:0] cmp,
  output logic          flag
);
  logic hit;
  assign hit = tick && en && (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      cmp  <= '0;
      flag <= 1'b0;
    end else begin
      if (en_wr)  en  <= wdata[0];
      if (cmp_wr) cmp <= wdata;
      if (hit)       flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end
endmodule

// File: rtl/task_timer.sv
module task_timer
  import task_timer_pkg::*;
#(
  parameter int CW  = 32,
  parameter int PW  = 8,
  parameter int NCH = 4,
  parameter int AW  = $clog2(ADDR_CH_BASE + 2 * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [CW-1:0]  reg_wdata,
  output logic [CW-1:0]  reg_rdata,
  input  logic           dbg_halt,
  output logic [NCH-1:0] irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_COUNT = AW'(ADDR_COUNT);
  localparam logic [AW-1:0] A_FLAGS = AW'(ADDR_FLAGS);

  logic                     ctl_en, ctl_frz;
  logic [PW-1:0]            ctl_psc;
  logic                     run, tick, load;
  logic [PW-1:0]            phase;
  logic [CW-1:0]            cnt, nxt;
  logic [NCH-1:0]           ch_en, flags, flag_clr;
  logic [NCH-1:0][CW-1:0]   cmp_q;

  assign run      = ctl_en && !(ctl_frz && dbg_halt);
  assign load     = reg_wr && (reg_addr == A_COUNT) && !ctl_en;
  assign flag_clr = (reg_wr && reg_addr == A_FLAGS) ? reg_wdata[NCH-1:0] : '0;
  assign irq      = flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_frz <= 1'b0;
      ctl_psc <= '0;
    end else if (reg_wr && reg_addr == A_CTRL) begin
      ctl_en  <= reg_wdata[CTRL_EN_BIT];
      ctl_frz <= reg_wdata[CTRL_FRZ_BIT];
      ctl_psc <= reg_wdata[CTRL_PSC_LSB +: PW];
    end
  end

  task_timer_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(!ctl_en),
    .div(ctl_psc), .phase(phase), .tick(tick)
  );

  task_timer_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
    .load_val(reg_wdata), .cnt(cnt), .nxt(nxt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] A_CEN = AW'(ADDR_CH_BASE + 2 * i);
    localparam logic [AW-1:0] A_CMP = AW'(ADDR_CH_BASE + 2 * i + 1);
    task_timer_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .en_wr(reg_wr && reg_addr == A_CEN),
      .cmp_wr(reg_wr && reg_addr == A_CMP),
      .wdata(reg_wdata), .tick(tick), .nxt(nxt), .clr(flag_clr[i]),
      .en(ch_en[i]), .cmp(cmp_q[i]), .flag(flags[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[CTRL_EN_BIT]           = ctl_en;
      reg_rdata[CTRL_FRZ_BIT]          = ctl_frz;
      reg_rdata[CTRL_PSC_LSB +: PW]    = ctl_psc;
    end else if (reg_addr == A_COUNT) begin
      reg_rdata = cnt;
    end else if (reg_addr == A_FLAGS) begin
      reg_rdata[NCH-1:0] = flags;
    end
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(ADDR_CH_BASE + 2 * i))     reg_rdata = CW'(ch_en[i]);
      if (reg_addr == AW'(ADDR_CH_BASE + 2 * i + 1)) reg_rdata = cmp_q[i];
    end
  end
endmodule

// File: rtl/task_timer_chk.sv
module task_timer_chk #(
  parameter int CW  = 32,
  parameter int PW  = 8,
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_en,
  input logic                   ctl_frz,
  input logic                   dbg_halt,
  input logic                   load,
  input logic [PW-1:0]          phase,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0]         ch_en,
  input logic [NCH-1:0]         flags,
  input logic [NCH-1:0]         flag_clr,
  input logic [NCH-1:0][CW-1:0] cmp_q
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) && !$past(load) |-> cnt == $past(cnt) + 1'b1);

  assert_no_load_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en && ctl_frz && dbg_halt |=> $stable(cnt) && $stable(phase));

  assert_phase_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> phase == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> cnt == $past(cmp_q[i]) && cnt != $past(cnt));

    assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[i]) |-> $past(ch_en[i]));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(flag_clr[i]));
  end
endmodule

bind task_timer task_timer_chk #(.CW(CW), .PW(PW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_frz(ctl_frz),
  .dbg_halt(dbg_halt), .load(load), .phase(phase), .cnt(cnt),
  .ch_en(ch_en), .flags(flags), .flag_clr(flag_clr), .cmp_q(cmp_q)
);

// File: tb/test_task_timer.sv
module test_task_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {divider N, enabled wait K, expected count = (K+1)/(N+1)}
  localparam logic [NVEC-1:0][3*16-1:0] VEC = '{
    {16'd0,   16'd9,   16'd10},
    {16'd1,   16'd9,   16'd5},
    {16'd2,   16'd10,  16'd3},
    {16'd4,   16'd13,  16'd2},
    {16'd255, 16'd300, 16'd1},
    {16'd3,   16'd2,   16'd0}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        dbg_halt = 0;
  logic [3:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_timer i_task_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halt(dbg_halt), .irq(irq)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    total++;
    if (reg_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic [3:0] exp, input string req);
    total++;
    if (irq !== exp) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit frz, input int psc);
    return {16'd0, psc[7:0], 6'd0, frz, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(0, 0, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1");
    chk(4, 0, "R1"); chk(5, 0, "R1"); chk_irq(0, "R1");

    // R2 divider cadence table
    for (int v = 0; v < NVEC; v++) begin
      wr(1, 0);
      wr(0, ctl(1, 0, int'(VEC[v][47:32])));
      repeat (int'(VEC[v][31:16])) @(negedge clk);
      wr(0, ctl(0, 0, int'(VEC[v][47:32])));
      chk(1, {16'd0, VEC[v][15:0]}, "R2");
    end

    // R3 counter write ignored while running, taken while stopped
    wr(1, 0);
    wr(0, ctl(1, 0, 255));
    wr(1, 32'h1234);
    chk(1, 0, "R3");
    wr(0, ctl(0, 0, 255));
    wr(1, 32'h1234);
    chk(1, 32'h1234, "R3");

    // R4 rollover raises no event
    wr(4, 1); wr(5, 5);
    wr(1, 32'hFFFF_FFFE);
    wr(0, ctl(1, 0, 0));
    repeat (2) @(negedge clk);
    wr(0, ctl(0, 0, 0));
    chk(1, 1, "R4");
    chk_irq(0, "R4");

    // R5 R6 R10 matches
    wr(1, 0);
    wr(5, 3); wr(6, 1); wr(7, 3); wr(8, 1); wr(9, 7); wr(11, 3);
    wr(0, ctl(1, 0, 0));
    @(negedge clk); chk(1, 1, "R5"); chk_irq(4'b0000, "R5");
    @(negedge clk); chk_irq(4'b0000, "R5");
    @(negedge clk); chk(1, 3, "R5"); chk_irq(4'b0011, "R10");
    repeat (4) @(negedge clk); chk_irq(4'b0111, "R5");
    chk(2, 32'h7, "R6");
    wr(0, ctl(0, 0, 0));

    // R7 write-one-to-clear and match priority
    wr(2, 32'h1);
    chk_irq(4'b0110, "R7");
    wr(2, 32'h6);
    chk_irq(4'b0000, "R7");
    wr(1, 0); wr(7, 2);
    wr(0, ctl(1, 0, 0));
    @(negedge clk);
    wr(2, 32'h2);
    chk(1, 2, "R7");
    chk_irq(4'b0010, "R7");
    wr(0, ctl(0, 0, 0));
    wr(2, 32'hF);

    // R8 debug freeze
    wr(1, 0);
    dbg_halt = 1;
    wr(0, ctl(1, 1, 0));
    repeat (5) @(negedge clk);
    chk(1, 0, "R8");
    dbg_halt = 0;
    repeat (4) @(negedge clk);
    chk(1, 4, "R8");
    wr(0, ctl(0, 1, 0));
    wr(1, 0);
    dbg_halt = 1;
    wr(0, ctl(1, 0, 0));
    repeat (4) @(negedge clk);
    chk(1, 4, "R8");
    wr(0, ctl(0, 0, 0));
    dbg_halt = 0;

    // R9 divider restarts after re-enable
    wr(1, 0);
    wr(0, ctl(1, 0, 3));
    @(negedge clk);
    wr(0, ctl(0, 0, 3));
    wr(0, ctl(1, 0, 3));
    repeat (3) @(negedge clk);
    chk(1, 0, "R9");
    @(negedge clk);
    chk(1, 1, "R9");
    wr(0, ctl(0, 0, 3));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule